// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block accepts configuration words from a host over a three-wire serial link and writes them into a bank of sixteen registers. The link uses a serial clock, a frame enable and a data input. While the enable is high, the host shifts in one 16-bit word with the most significant bit first. The upper nibble of the word chooses a register and the lower twelve bits are the value written to it. Transfers carry writes only. The bank cannot be read back over the link.

The word is committed only when the enable falls. At that point the serial-domain logic checks that exactly sixteen clock edges arrived during the frame. It then holds the word steady and flips a toggle. The toggle passes through a two-flop synchronizer into the system clock domain, and the addressed register is written there. The whole bank is available as a flat output.

The most-used settings are also decoded onto their own outputs:
- two readout-reversal flags;
- a 4-bit multiplexer bypass code;
- a 12-bit gain word and its 4-bit gain code.

The serial clock may run at up to 20 MHz. It has no fixed phase relation to the system clock.

Top module: `spi_cfg_port`

## Requirements
- R1: `sdi_i` is sampled on each rising edge of `sck_i` while `sen_i` is high. The first sampled bit becomes word bit 15 and the sixteenth becomes bit 0.
- R2: On commit, word bits 15:12 select register index 0..15 and bits 11:0 are written to it. Register a occupies `regs_o[a*12 +: 12]`. No other register changes.
- R3: Register 15 stores only data bits 8:0. Its bits 11:9 always read 0, even after a write of all ones.
- R4: A frame in which other than exactly 16 rising `sck_i` edges occur while `sen_i` is high is discarded: no register changes. This covers both 15-edge and 17-edge frames.
- R5: For a valid frame, the addressed register shows the new value right after the third rising edge of `clk_i` that follows the fall of `sen_i`. It still shows the old value after the second edge.
- R6: Rising edges of `sck_i` while `sen_i` is low change no register. Without a committed frame, `regs_o` holds its value on every clock.
- R7: While `rst_ni` is low, all registers are 0. This makes `bypass_o` 4'b0000, which means no bypass, and the reversal flags 0, which means normal direction.
- R8: Register 10 is decoded as follows: bit 0 drives `rev_x_o`, bit 1 drives `rev_y_o`, and bits 7:4 drive `bypass_o`. Register 12 drives `gain_o`, and its bits 3:0 drive `gain_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| sck_i | input | 1 | Serial clock from host |
| sen_i | input | 1 | Frame enable, high during a transfer |
| sdi_i | input | 1 | Serial data, MSB first |
| regs_o | output | 192 | All sixteen 12-bit registers, register a at bits a*12+11:a*12 |
| rev_x_o | output | 1 | Horizontal readout reversal flag |
| rev_y_o | output | 1 | Vertical readout reversal flag |
| bypass_o | output | 4 | Multiplexer bypass code, 0000 = none |
| gain_o | output | 12 | Gain register |
| gain_code_o | output | 4 | Gain code sub-field |

## Verification
The assertions are checked on every system clock:
- the commit strobe lasts a single cycle;
- the bank changes only when that strobe fires;
- each strobe lands the masked data in the addressed register;
- the narrow register's upper bits stay clear.

Some behaviours only the bench scenarios can show. These are frame-length rejection, MSB-first bit ordering, the exact three-edge commit latency after the enable falls, and the immunity to serial clocks outside a frame. For these, the bench compares a behavioural model with every output on every clock.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned DATA_W      = 12;
  localparam int unsigned NUM_REGS    = 1 << ADDR_W;
  localparam int unsigned NARROW_ADDR = 15;
  localparam int unsigned NARROW_W    = 9;
  localparam int unsigned CTRL_ADDR   = 10;
  localparam int unsigned REVX_BIT    = 0;
  localparam int unsigned REVY_BIT    = 1;
  localparam int unsigned BYP_LSB     = 4;
  localparam int unsigned BYP_W       = 4;
  localparam int unsigned GAIN_ADDR   = 12;
  localparam int unsigned GCODE_W     = 4;

  function automatic logic [DATA_W-1:0] reg_mask(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] m;
    m = '1;
    if (a == ADDR_W'(NARROW_ADDR)) m = DATA_W'((1 << NARROW_W) - 1);
    return m;
  endfunction
endpackage

// File: rtl/spi_cfg_shift.sv
module spi_cfg_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sen_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              tgl_o
);
  localparam int unsigned CNT_MAX = WORD_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic              fr_rst_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] hold_q;
  logic              tgl_q;

  // count and shift are cleared whenever the frame is closed
  assign fr_rst_n = rst_ni & sen_i;

  always_ff @(posedge sck_i or negedge fr_rst_n) begin
    if (!fr_rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      shreg_q <= {shreg_q[WORD_W-2:0], sdi_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  // commit on frame close, only with exact length
  always_ff @(negedge sen_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else if (cnt_q == CNT_W'(WORD_W)) begin
      hold_q <= shreg_q;
      tgl_q  <= ~tgl_q;
    end
  end

  assign word_o = hold_q;
  assign tgl_o  = tgl_q;
endmodule

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = sync_q[STAGES] ^ sync_q[STAGES-1];

  p_one_cycle_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NR = NUM_REGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [NR*DW-1:0] regs_o
);
  logic [DW-1:0] regs_q [NR];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = AW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == MY_ADDR) regs_q[g] <= wr_data_i & reg_mask(MY_ADDR);
    end
    assign regs_o[g*DW +: DW] = regs_q[g];
  end

  p_stable_without_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_q[$past(wr_addr_i)] == ($past(wr_data_i) & reg_mask($past(wr_addr_i))));

  p_narrow_upper_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[NARROW_ADDR][DW-1:NARROW_W] == '0);
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NR = NUM_REGS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             sen_i,
  input  logic             sdi_i,
  output logic [NR*DW-1:0] regs_o,
  output logic             rev_x_o,
  output logic             rev_y_o,
  output logic [BYP_W-1:0] bypass_o,
  output logic [DW-1:0]    gain_o,
  output logic [GCODE_W-1:0] gain_code_o
);
  localparam int unsigned WORD_W = AW + DW;

  logic [WORD_W-1:0] word;
  logic              tgl;
  logic              wr_pulse;
  logic [DW-1:0]     ctrl_reg;

  spi_cfg_shift #(.WORD_W(WORD_W)) u_shift (
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .sen_i  (sen_i),
    .sdi_i  (sdi_i),
    .word_o (word),
    .tgl_o  (tgl)
  );

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tgl_i   (tgl),
    .pulse_o (wr_pulse)
  );

  // word is held static from commit until well after the strobe
  spi_cfg_bank #(.AW(AW), .DW(DW), .NR(NR)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_pulse),
    .wr_addr_i (word[WORD_W-1 -: AW]),
    .wr_data_i (word[DW-1:0]),
    .regs_o    (regs_o)
  );

  assign ctrl_reg    = regs_o[CTRL_ADDR*DW +: DW];
  assign rev_x_o     = ctrl_reg[REVX_BIT];
  assign rev_y_o     = ctrl_reg[REVY_BIT];
  assign bypass_o    = ctrl_reg[BYP_LSB +: BYP_W];
  assign gain_o      = regs_o[GAIN_ADDR*DW +: DW];
  assign gain_code_o = gain_o[GCODE_W-1:0];
endmodule

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, sen = 1'b0, sdi = 1'b0;
  logic [191:0] regs;
  logic rev_x, rev_y;
  logic [3:0] bypass, gcode;
  logic [11:0] gain;

  spi_cfg_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .sen_i(sen), .sdi_i(sdi),
    .regs_o(regs), .rev_x_o(rev_x), .rev_y_o(rev_y), .bypass_o(bypass),
    .gain_o(gain), .gain_code_o(gcode)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R7";
  logic [11:0] exp_q [16];
  int pend_cnt = 0;
  logic [15:0] pend_word;
  bit run = 0;

  function automatic logic [191:0] exp_flat();
    logic [191:0] f;
    for (int a = 0; a < 16; a++) f[a*12 +: 12] = exp_q[a];
    return f;
  endfunction

  initial for (int a = 0; a < 16; a++) exp_q[a] = '0;

  // behavioural model plus per-clock compare
  always @(posedge clk) begin
    if (pend_cnt > 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0)
        exp_q[pend_word[15:12]] = pend_word[11:0] & (pend_word[15:12] == 4'd15 ? 12'h1FF : 12'hFFF);
    end
    #2;
    if (run) begin
      logic [191:0] ef;
      ef = exp_flat();
      checks++;
      if (regs !== ef) begin
        fails++;
        $display("FAIL %s regs actual=%h expected=%h", cur_req, regs, ef);
      end
      checks++;
      if ({rev_x, rev_y, bypass, gain, gcode} !==
          {exp_q[10][0], exp_q[10][1], exp_q[10][7:4], exp_q[12], exp_q[12][3:0]}) begin
        fails++;
        $display("FAIL R8 fields actual=%b %b %h %h %h expected=%b %b %h %h %h",
                 rev_x, rev_y, bypass, gain, gcode,
                 exp_q[10][0], exp_q[10][1], exp_q[10][7:4], exp_q[12], exp_q[12][3:0]);
      end
    end
  end

  task automatic send_bits(input logic [31:0] w, input int n);
    @(negedge clk) sen = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) begin sck = 1'b0; sdi = w[i]; end
      @(negedge clk);
      @(negedge clk) sck = 1'b1;
      @(negedge clk);
    end
    @(negedge clk) sck = 1'b0;
    @(negedge clk) begin
      sen = 1'b0;
      if (n == 16) begin pend_word = w[15:0]; pend_cnt = 3; end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic idle_sck(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin sck = 1'b1; sdi = i[0]; end
      @(negedge clk) sck = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_val(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    run = 1;
    cur_req = "R7";
    repeat (3) @(negedge clk);
    check_val("R7 bypass reset", {8'h0, bypass}, 12'h000);
    @(negedge clk) rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    cur_req = "R1 R2";
    send_bits(32'h3ABC, 16);
    check_val("R1", regs[3*12 +: 12], 12'hABC);
    send_bits(32'h8001, 16);
    check_val("R1 msb order", regs[8*12 +: 12], 12'h001);

    cur_req = "R3";
    send_bits(32'hFFFF, 16);
    check_val("R3", regs[15*12 +: 12], 12'h1FF);

    cur_req = "R8";
    send_bits(32'hA0F3, 16);
    check_val("R8 bypass", {8'h0, bypass}, 12'h00F);
    send_bits(32'hC5A7, 16);
    check_val("R8 gain code", {8'h0, gcode}, 12'h007);

    cur_req = "R4";
    send_bits(32'h3555, 15);
    check_val("R4 short", regs[3*12 +: 12], 12'hABC);
    send_bits(32'h0_6AAA << 1, 17);
    check_val("R4 long", regs[6*12 +: 12], 12'h000);

    cur_req = "R6";
    idle_sck(20);
    check_val("R6", regs[3*12 +: 12], 12'hABC);

    cur_req = "R5 R2";
    send_bits(32'h3123, 16);
    check_val("R2 overwrite", regs[3*12 +: 12], 12'h123);
    send_bits(32'hA002, 16);
    check_val("R8 rev_y", {10'h0, rev_y, rev_x}, 12'h002);

    // rapid frames with short gap
    cur_req = "R5";
    send_bits(32'h1111, 16);
    send_bits(32'h2222, 16);
    check_val("R5", regs[2*12 +: 12], 12'h222);

    repeat (10) @(negedge clk);
    run = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule